// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block works out the memory address of an instruction operand. It does this in eight ways, and a 4-bit mode code picks the way. The inputs are the address field of the instruction and the location of that field in memory. That location is the program counter value after the opcode fetch. The block also takes the value of the selected base register and the value of the selected index register. Each mode adds a fixed subset of these four terms. Immediate mode returns the location of the field, because the operand itself is stored there. Relative mode adds the field to that same location, not to the address of the next instruction.

All additions wrap modulo 2^ADDR_W, and no overflow is reported. The eight codes above the defined ones raise an invalid flag and force the address to zero. A parameter selects whether a register sits at the output. With the default, the output is registered and the result appears one clock after its inputs. The block does not access memory, translate segments or fetch operands.

Top module: `ea_calc_unit`

## Requirements
- R1: While `rst` is high, and after the first clock edge in reset, `ea_o` is 0 and `bad_mode_o` is 0.
- R2: Mode 0 (direct) gives `ea_o` = `field_i`.
- R3: Mode 1 (immediate) gives `ea_o` = `field_loc_i`.
- R4: Mode 2 (register indirect) gives `ea_o` = `base_i`.
- R5: Mode 3 (relative) gives `ea_o` = `field_loc_i` + `field_i`.
- R6: Mode 4 (indexed) gives `ea_o` = `field_i` + `index_i`.
- R7: Mode 5 (based) gives `ea_o` = `base_i` + `field_i`.
- R8: Mode 6 (based indexed) gives `ea_o` = `base_i` + `index_i`.
- R9: Mode 7 (based indexed with displacement) gives `ea_o` = `base_i` + `index_i` + `field_i`.
- R10: Mode codes 8 to 15 set `bad_mode_o` to 1 and `ea_o` to 0. Codes 0 to 7 set `bad_mode_o` to 0.
- R11: With the default registered output, the outputs change only at a rising clock edge. They show the inputs sampled at that edge.
- R12: Every sum wraps modulo 2^16 at the default width. A carry out of the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | ADDR_W | Address field / displacement of the instruction |
| field_loc_i | input | ADDR_W | Memory location of the address field |
| base_i | input | ADDR_W | Value of the selected base register |
| index_i | input | ADDR_W | Value of the selected index register |
| ea_o | output | ADDR_W | Effective address |
| bad_mode_o | output | 1 | Mode code is undefined |

## Verification
Wrap-around is the case that random operands seldom reach cleanly. In particular, the three-term sum in mode 7 can carry twice past the top bit. Directed vectors with all-ones base, index and field, and a relative sum that just crosses zero, produce these carries on purpose. The register latency is checked by sampling the outputs just after new inputs are driven and before the next edge. Random vectors then cover all sixteen codes, so the undefined codes are also mixed in between valid ones.

// File: rtl/eau_pkg.sv
package eau_pkg;

    localparam int MODE_W = 4;
    localparam int N_TERMS = 4;

    // term positions in the operand vector
    localparam int T_FIELD = 0;
    localparam int T_LOC   = 1;
    localparam int T_BASE  = 2;
    localparam int T_INDEX = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT     = 4'd0,
        AM_IMMEDIATE  = 4'd1,
        AM_REG_IND    = 4'd2,
        AM_RELATIVE   = 4'd3,
        AM_INDEXED    = 4'd4,
        AM_BASED      = 4'd5,
        AM_BASE_IDX   = 4'd6,
        AM_BASE_IDX_D = 4'd7
    } addr_mode_e;

    typedef struct packed {
        logic [N_TERMS-1:0] term_en;
        logic               bad;
    } term_sel_t;

    function automatic term_sel_t decode_mode(input logic [MODE_W-1:0] code);
        term_sel_t s;
        s.term_en = '0;
        s.bad     = 1'b0;
        case (code)
            AM_DIRECT:     s.term_en[T_FIELD] = 1'b1;
            AM_IMMEDIATE:  s.term_en[T_LOC]   = 1'b1;
            AM_REG_IND:    s.term_en[T_BASE]  = 1'b1;
            AM_RELATIVE: begin
                s.term_en[T_LOC]   = 1'b1;
                s.term_en[T_FIELD] = 1'b1;
            end
            AM_INDEXED: begin
                s.term_en[T_FIELD] = 1'b1;
                s.term_en[T_INDEX] = 1'b1;
            end
            AM_BASED: begin
                s.term_en[T_BASE]  = 1'b1;
                s.term_en[T_FIELD] = 1'b1;
            end
            AM_BASE_IDX: begin
                s.term_en[T_BASE]  = 1'b1;
                s.term_en[T_INDEX] = 1'b1;
            end
            AM_BASE_IDX_D: begin
                s.term_en[T_BASE]  = 1'b1;
                s.term_en[T_INDEX] = 1'b1;
                s.term_en[T_FIELD] = 1'b1;
            end
            default:       s.bad = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eau_mode_decode.sv
module eau_mode_decode
    import eau_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output term_sel_t         sel_o
);

    always_comb begin
        sel_o = decode_mode(mode_i);
    end

endmodule

// File: rtl/eau_term_sum.sv
module eau_term_sum #(
    parameter int ADDR_W  = 16,
    parameter int N_TERMS = 4
) (
    input  logic [N_TERMS-1:0][ADDR_W-1:0] term_i,
    input  logic [N_TERMS-1:0]             en_i,
    output logic [ADDR_W-1:0]              sum_o
);

    logic [N_TERMS-1:0][ADDR_W-1:0] gated;

    for (genvar k = 0; k < N_TERMS; k++) begin : g_gate
        assign gated[k] = term_i[k] & {ADDR_W{en_i[k]}};
    end

    // modulo-2^ADDR_W accumulation, carries past the top bit are dropped
    always_comb begin
        logic [ADDR_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < N_TERMS; k++) begin
            acc = acc + gated[k];
        end
        sum_o = acc;
    end

endmodule

// File: rtl/eau_out_stage.sv
module eau_out_stage #(
    parameter int ADDR_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bad_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bad_o
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_o <= '0;
                bad_o  <= 1'b0;
            end else begin
                addr_o <= addr_i;
                bad_o  <= bad_i;
            end
        end

        AST_PIPE_VALID: assert property (@(posedge clk) disable iff (rst)
            !bad_i |=> (!bad_o && addr_o == $past(addr_i)));  // R11
        AST_PIPE_BAD: assert property (@(posedge clk) disable iff (rst)
            bad_i |=> (bad_o && addr_o == '0));  // R10
    end else begin : g_comb
        assign addr_o = addr_i;
        assign bad_o  = bad_i;
    end

endmodule

// File: rtl/ea_calc_unit.sv
module ea_calc_unit
    import eau_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [ADDR_W-1:0]   field_i,
    input  logic [ADDR_W-1:0]   field_loc_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   index_i,
    output logic [ADDR_W-1:0]   ea_o,
    output logic                bad_mode_o
);

    term_sel_t                      sel_w;
    logic [N_TERMS-1:0][ADDR_W-1:0] terms_w;
    logic [ADDR_W-1:0]              sum_w;

    assign terms_w[T_FIELD] = field_i;
    assign terms_w[T_LOC]   = field_loc_i;
    assign terms_w[T_BASE]  = base_i;
    assign terms_w[T_INDEX] = index_i;

    eau_mode_decode u_dec (
        .mode_i (mode_i),
        .sel_o  (sel_w)
    );

    eau_term_sum #(
        .ADDR_W  (ADDR_W),
        .N_TERMS (N_TERMS)
    ) u_sum (
        .term_i (terms_w),
        .en_i   (sel_w.term_en),
        .sum_o  (sum_w)
    );

    eau_out_stage #(
        .ADDR_W  (ADDR_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .addr_i (sum_w),
        .bad_i  (sel_w.bad),
        .addr_o (ea_o),
        .bad_o  (bad_mode_o)
    );

    AST_DIRECT_FIELD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AM_DIRECT) |-> (sum_w == field_i));  // R2
    AST_IMMED_LOC: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AM_IMMEDIATE) |-> (sum_w == field_loc_i));  // R3
    AST_RELATIVE_SUM: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AM_RELATIVE) |-> (sum_w == ADDR_W'(field_loc_i + field_i)));  // R5
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        sel_w.bad |-> (sum_w == '0));  // R10
    AST_LOW_CODES_OK: assert property (@(posedge clk) disable iff (rst)
        !mode_i[MODE_W-1] |-> !sel_w.bad);  // R10

endmodule

// File: tb/ea_calc_unit_tb_top.sv
module ea_calc_unit_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    mode = '0;
    logic [AW-1:0] field = '0, loc = '0, base = '0, index = '0;
    logic [AW-1:0] ea;
    logic          bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] prev_ea;
    logic          prev_bad;

    always #4 clk = ~clk;  // 125 MHz

    ea_calc_unit #(.ADDR_W(AW), .REG_OUT(1'b1)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .field_i     (field),
        .field_loc_i (loc),
        .base_i      (base),
        .index_i     (index),
        .ea_o        (ea),
        .bad_mode_o  (bad)
    );

    function automatic logic [AW-1:0] exp_ea(input logic [3:0] m, input logic [AW-1:0] f,
                                             input logic [AW-1:0] l, input logic [AW-1:0] b,
                                             input logic [AW-1:0] x);
        case (m)
            4'd0: return f;
            4'd1: return l;
            4'd2: return b;
            4'd3: return AW'(l + f);
            4'd4: return AW'(f + x);
            4'd5: return AW'(b + f);
            4'd6: return AW'(b + x);
            4'd7: return AW'(b + x + f);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] got_a, input logic got_b,
                         input logic [AW-1:0] exp_a, input logic exp_b);
        checks++;
        if (got_a !== exp_a || got_b !== exp_b) begin
            fails++;
            $display("FAIL %s: ea=%h bad=%b expected ea=%h bad=%b", tag, got_a, got_b, exp_a, exp_b);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic apply(input string tag, input logic [3:0] m, input logic [AW-1:0] f,
                         input logic [AW-1:0] l, input logic [AW-1:0] b, input logic [AW-1:0] x);
        @(negedge clk);
        prev_ea  = ea;
        prev_bad = bad;
        mode = m; field = f; loc = l; base = b; index = x;
        #1;
        // R11: nothing moves before the rising edge
        check("R11", ea, bad, prev_ea, prev_bad);
        @(negedge clk);
        check(tag, ea, bad, exp_ea(m, f, l, b, x), (m > 4'd7));
    endtask

    initial begin
        void'($urandom(32'h5EED_0417));
        repeat (3) @(negedge clk);
        check("R1", ea, bad, '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // directed: worked example values
        apply("R2", 4'd0, 16'd400, 16'd301, 16'd200, 16'd200);
        apply("R3", 4'd1, 16'd400, 16'd301, 16'd200, 16'd200);
        apply("R4", 4'd2, 16'd400, 16'd301, 16'd200, 16'd200);
        apply("R5", 4'd3, 16'd400, 16'd301, 16'd200, 16'd200);
        apply("R6", 4'd4, 16'd400, 16'd301, 16'd200, 16'd200);
        apply("R7", 4'd5, 16'h0100, 16'd301, 16'h2000, 16'd7);
        apply("R8", 4'd6, 16'h0100, 16'd301, 16'h2000, 16'h0030);
        apply("R9", 4'd7, 16'h2000, 16'd301, 16'h0040, 16'h0003);
        apply("R10", 4'd8, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        apply("R10", 4'd15, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);

        // directed wrap cases
        apply("R12", 4'd7, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF);
        apply("R12", 4'd3, 16'h0002, 16'hFFFF, 16'h0000, 16'h0000);
        apply("R12", 4'd4, 16'h8000, 16'h0000, 16'h0000, 16'h8000);

        // reset in mid-run returns outputs to zero
        @(negedge clk);
        rst = 1'b1;
        mode = 4'd9;
        @(negedge clk);
        check("R1", ea, bad, '0, 1'b0);
        rst = 1'b0;

        // random vectors across all codes
        for (int n = 0; n < 400; n++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            apply(req_of(m), m, AW'($urandom), AW'($urandom), AW'($urandom), AW'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule